// File: doc/BRIEF.md
# GPIO Bank Register Block

This block is a general-purpose I/O port of `NUM_PINS` pins (64 by default) in banks of 32, reached through a simple 32-bit word bus. Each pin has four pieces of state. A direction bit chooses input or output. An output data bit sets the value the pad drives. A filter-bypass bit chooses the filtered or the raw input. The pin's level can be read back at any time.

Software never writes the output data directly. Two write-only strobe registers each take a mask. One raises the selected outputs and the other lowers them. This lets a single pin change without a read-modify-write. The pad driver itself sits outside the block: `pad_out` is the value to drive and `pad_oe` enables the driver.

Every pad input first passes through a two-flop synchronizer. It then passes through a per-pin glitch filter, which is a two-state machine:
- In `FLT_HOLD`, the accepted level matches the synchronized input.
- A mismatch takes the transition *hold→qualify* into `FLT_QUAL`, which starts a run counter.
- While in `FLT_QUAL`, a sample equal to the accepted level takes *qualify→hold (reject)* and drops the run.
- A run of `FILT_CYCLES` mismatching samples takes *qualify→hold (accept)* and loads the new level.

For a given pin, the level register returns the synchronized input when bypass is set, and the filter output otherwise.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), all output data is 0 (`pad_out` all 0), and the direction and bypass registers read 0.
- R2: The direction register at offset 0x01c is read/write. A 1 makes the pin an output, with `pad_oe` high, and a 0 makes it an input.
- R3: Writing the set register at 0x034 forces to 1 the output bits whose mask bits are 1. Mask bits of 0 leave outputs unchanged, and the register reads back 0.
- R4: Writing the clear register at 0x04c forces to 0 the output bits whose mask bits are 1. Mask bits of 0 leave outputs unchanged, and the register reads back 0.
- R5: The level register at 0x004 returns the actual pad state, for output pins as well as inputs. Writes to it change no state or output.
- R6: Pin n is found at register offset + (n/32)*4, in bit n mod 32.
- R7: The bypass register at 0x094 is read/write. A 1 makes that pin's level show the synchronized input two clocks after the pad changes, without filtering.
- R8: With bypass at 0, a new input level is accepted only after 3 consecutive synchronized samples agree. A pulse shorter than that never appears at the level register.
- R9: A read request returns data with `bus_rd_valid` high exactly one cycle later. Offsets that are unmapped or write-only read as 0.
- R10: Levels read while pins drive high, once cleared and then written back to the set register, restore the same levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Word write strobe |
| bus_rd_en | input | 1 | Word read request |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rd_valid |
| bus_rd_valid | output | 1 | High one cycle after a read request |
| pad_in | input | NUM_PINS | Raw pad levels |
| pad_out | output | NUM_PINS | Output data toward pads |
| pad_oe | output | NUM_PINS | Output enable per pin |

## Verification
The hardest case to reach is the exact edge of the glitch filter. The level must still read the old value when sampled in the cycle the filter accepts, and read the new value one cycle later. A pulse two cycles long must never appear. The stimulus changes a pad input on a known falling edge and then times a read to land on a chosen rising edge. The same timing, on a bypassed pin, shows the level two clocks after the change. The output pins are looped back onto `pad_in` so that levels read from driven pins reflect the real pad, which the save-and-restore sequence depends on.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned BANK_W = 32;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_LEVEL = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_DIR   = 12'h01c;
    localparam logic [ADDR_W-1:0] OFF_SET   = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h04c;
    localparam logic [ADDR_W-1:0] OFF_BYP   = 12'h094;

    typedef enum logic {
        FLT_HOLD = 1'b0,
        FLT_QUAL = 1'b1
    } flt_state_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter import gpio_bank_pkg::*; #(
    parameter int unsigned FILT_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic filt_out
);
    localparam int unsigned CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            filt_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            filt_q  <= filt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        filt_d  = filt_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (sync_in != filt_q) begin
                    state_d = FLT_QUAL;
                    cnt_d   = CNT_W'(1);
                end
            end
            FLT_QUAL: begin
                if (sync_in == filt_q) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                    filt_d  = sync_in;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = FLT_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    assign filt_out = filt_q;

    assert_accept_from_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(state_q) == FLT_QUAL && $past(sync_in) == filt_q));

    assert_reject_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_QUAL && sync_in == filt_q) |=> (state_q == FLT_HOLD && $stable(filt_q)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_HOLD) |=> $stable(filt_q));
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile import gpio_bank_pkg::*; #(
    parameter int unsigned NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BANK_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] level_in,
    output logic [BANK_W-1:0]   rdata,
    output logic                rd_valid,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] byp_q
);
    localparam int unsigned NUM_BANKS = NUM_PINS / BANK_W;

    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rd;
    logic [BANK_W-1:0]                rd_mux;
    logic [BANK_W-1:0]                rdata_q;
    logic                             rd_valid_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4 * b);
        logic [BANK_W-1:0] dir_r, out_r, byp_r;
        logic              wr_dir, wr_set, wr_clr, wr_byp;

        assign wr_dir = wr_en && (addr == OFF_DIR + STEP);
        assign wr_set = wr_en && (addr == OFF_SET + STEP);
        assign wr_clr = wr_en && (addr == OFF_CLR + STEP);
        assign wr_byp = wr_en && (addr == OFF_BYP + STEP);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dir_r <= '0;
                out_r <= '0;
                byp_r <= '0;
            end else begin
                if (wr_dir) dir_r <= wdata;
                if (wr_byp) byp_r <= wdata;
                if (wr_set)      out_r <= out_r | wdata;
                else if (wr_clr) out_r <= out_r & ~wdata;
            end
        end

        assign bank_rd[b] =
            (addr == OFF_LEVEL + STEP) ? level_in[b*BANK_W +: BANK_W] :
            (addr == OFF_DIR + STEP)   ? dir_r :
            (addr == OFF_BYP + STEP)   ? byp_r : '0;

        assign dir_q[b*BANK_W +: BANK_W] = dir_r;
        assign out_q[b*BANK_W +: BANK_W] = out_r;
        assign byp_q[b*BANK_W +: BANK_W] = byp_r;
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            rd_mux = rd_mux | bank_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) rdata_q <= rd_mux;
        end
    end

    assign rdata    = rdata_q;
    assign rd_valid = rd_valid_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs import gpio_bank_pkg::*; #(
    parameter int unsigned NUM_PINS    = 64,
    parameter int unsigned FILT_CYCLES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BANK_W-1:0]   bus_wdata,
    output logic [BANK_W-1:0]   bus_rdata,
    output logic                bus_rd_valid,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int unsigned NUM_BANKS = NUM_PINS / BANK_W;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_filt;
    logic [NUM_PINS-1:0] pin_level;
    logic [NUM_PINS-1:0] byp_bits;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        gpio_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (pin_sync[p]),
            .filt_out (pin_filt[p])
        );
    end

    assign pin_level = (byp_bits & pin_sync) | (~byp_bits & pin_filt);

    gpio_bank_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .rd_en    (bus_rd_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .level_in (pin_level),
        .rdata    (bus_rdata),
        .rd_valid (bus_rd_valid),
        .dir_q    (pad_oe),
        .out_q    (pad_out),
        .byp_q    (byp_bits)
    );

    assert_rd_valid_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> bus_rd_valid);

    assert_rd_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> !bus_rd_valid);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4 * b);

        assert_set_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr == OFF_SET + STEP) |=>
            ((pad_out[b*BANK_W +: BANK_W] & $past(bus_wdata)) == $past(bus_wdata)));

        assert_clr_lowers_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr == OFF_CLR + STEP) |=>
            ((pad_out[b*BANK_W +: BANK_W] & $past(bus_wdata)) == '0));

        assert_level_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_en && bus_addr == OFF_LEVEL + STEP) |=>
            ($stable(pad_out) && $stable(pad_oe) && $stable(byp_bits)));
    end
endmodule

// File: tb/gpio_bank_regs_tb_top.sv
module gpio_bank_regs_tb_top;
    localparam int NP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rd_valid;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] ext_in = '0;

    logic [NP-1:0] m_dir = '0;
    logic [NP-1:0] m_out = '0;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_in);

    gpio_bank_regs dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_en    (bus_wr_en),
        .bus_rd_en    (bus_rd_en),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rd_valid (bus_rd_valid),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe)
    );

    function automatic logic [31:0] lvl_exp(int bank);
        logic [NP-1:0] v;
        v = (m_dir & m_out) | (~m_dir & ext_in);
        return v[bank*32 +: 32];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd_en = 1'b1;
        bus_addr  = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bus_rd_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected read data act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", {32'h0, pad_oe[63:32] | pad_oe[31:0]}, 64'h0);
        check("R1 pad_out", pad_out, 64'h0);
        bus_read(12'h01c, 32'h0, "R1 dir bank0");
        bus_read(12'h020, 32'h0, "R1 dir bank1");
        bus_read(12'h094, 32'h0, "R1 bypass bank0");
        bus_read(12'h004, 32'h0, "R1 level bank0");

        // R2 / R6 direction
        bus_write(12'h01c, 32'hFF00_0000);
        bus_write(12'h020, 32'h0000_FFFF);
        m_dir = {32'h0000_FFFF, 32'hFF00_0000};
        @(negedge clk);
        check("R2 pad_oe", pad_oe, m_dir);
        bus_read(12'h01c, 32'hFF00_0000, "R2 dir bank0 readback");
        bus_read(12'h020, 32'h0000_FFFF, "R6 dir bank1 readback");

        // R3 set
        bus_write(12'h034, 32'h0F00_0000);
        m_out[31:0] = 32'h0F00_0000;
        @(negedge clk);
        check("R3 pad_out after set", pad_out, m_out);
        bus_read(12'h034, 32'h0, "R3 set reads zero");
        // R6 bank 1 pins 32..39
        bus_write(12'h038, 32'h0000_00FF);
        m_out[63:32] = 32'h0000_00FF;
        @(negedge clk);
        check("R6 pad_out bank1", pad_out, m_out);
        repeat (8) @(negedge clk);
        bus_read(12'h004, lvl_exp(0), "R3 level bank0 after set");
        bus_read(12'h008, lvl_exp(1), "R6 level bank1 after set");

        // R3 zero mask leaves outputs
        bus_write(12'h034, 32'h0);
        @(negedge clk);
        check("R3 zero mask no change", pad_out, m_out);

        // R4 clear
        bus_write(12'h04c, 32'h0300_0000);
        m_out[31:0] = 32'h0C00_0000;
        @(negedge clk);
        check("R4 pad_out after clear", pad_out, m_out);
        bus_read(12'h04c, 32'h0, "R4 clear reads zero");
        bus_write(12'h050, 32'h0);
        @(negedge clk);
        check("R4 zero mask no change", pad_out, m_out);

        // R5 input levels and output pads ignore external drive
        @(negedge clk);
        ext_in[63:48] = 16'hA5A5;
        ext_in[3:0]   = 4'b1001;
        ext_in[31]    = 1'b1;
        repeat (10) @(negedge clk);
        bus_read(12'h004, lvl_exp(0), "R5 level bank0 inputs");
        bus_read(12'h008, lvl_exp(1), "R5 level bank1 inputs");

        // R5 write to level register ignored
        bus_write(12'h004, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R5 level write pad_out", pad_out, m_out);
        check("R5 level write pad_oe", pad_oe, m_dir);
        bus_read(12'h01c, 32'hFF00_0000, "R5 dir after level write");
        bus_read(12'h004, lvl_exp(0), "R5 level after level write");

        // R9 unmapped reads
        bus_read(12'h000, 32'h0, "R9 unmapped 0x000");
        bus_read(12'h00c, 32'h0, "R9 unmapped 0x00c");
        bus_read(12'h0fc, 32'h0, "R9 unmapped 0x0fc");
        @(negedge clk);
        check("R9 rd_valid idle", {63'h0, bus_rd_valid}, 64'h0);

        // R7 bypass register
        bus_write(12'h094, 32'h0000_0080);
        bus_read(12'h094, 32'h0000_0080, "R7 bypass readback");
        repeat (4) @(negedge clk);

        // R7 bypassed pin 7 visible two clocks after change
        @(negedge clk);
        ext_in[7] = 1'b1;
        @(negedge clk);
        bus_read(12'h004, lvl_exp(0), "R7 bypass level at 2 clocks");
        ext_in[7] = 1'b0;
        repeat (10) @(negedge clk);

        // R8 filter acceptance boundary on pin 5
        @(negedge clk);
        ext_in[5] = 1'b1;
        repeat (1) @(negedge clk);
        bus_read(12'h004, lvl_exp(0) & ~32'h20, "R8 filtered level at 2 clocks");
        bus_read(12'h004, lvl_exp(0) & ~32'h20, "R8 filtered level at 4 clocks");
        bus_read(12'h004, lvl_exp(0), "R8 filtered level at 6 clocks");
        repeat (6) @(negedge clk);

        // R8 two-cycle glitch on pin 6 rejected
        @(negedge clk);
        ext_in[6] = 1'b1;
        repeat (2) @(negedge clk);
        ext_in[6] = 1'b0;
        repeat (10) @(negedge clk);
        bus_read(12'h004, lvl_exp(0), "R8 glitch rejected");

        // R10 save and restore through set register
        saved = lvl_exp(1);
        bus_read(12'h008, saved, "R10 level saved");
        bus_write(12'h050, 32'hFFFF_FFFF);
        m_out[63:32] = 32'h0;
        repeat (8) @(negedge clk);
        bus_read(12'h008, lvl_exp(1), "R10 level after clear");
        bus_write(12'h038, saved);
        m_out[63:32] = saved;
        repeat (8) @(negedge clk);
        bus_read(12'h008, saved, "R10 level restored");

        repeat (4) @(negedge clk);
        check("R9 no pending reads", {32'h0, 32'(exp_q.size())}, 64'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule